// File: doc/BRIEF.md
# Census Transform Disparity Cost Generator

This block produces, for every pixel of a stereo pair, a vector of matching costs over 64 candidate disparities. It feeds a belief-propagation stage that needs one cost per disparity label. The current-image pixel arrives as a 5×5 window of raw intensities. For each accepted beat the block also receives LANES reference-image windows, one per candidate disparity. It forms a 24-bit census signature of the current window and of each reference window. The cost for a disparity is the number of signature bits that differ between the two.

One pixel takes 64/LANES accepted beats. With LANES at 32, 16 or 8, a pixel takes 2, 4 or 8 beats, so a 16×16 tile of 256 pixels takes 256·64/LANES cycles. This lets the cycle count of cost generation be matched to the iteration budget of the downstream stage (one, two or three inner iterations). Candidate disparities whose reference pixel would lie left of the image edge get the maximum cost. The full vector is presented with a one-cycle strobe once every disparity of the pixel has been computed.

Top module: `census_cost_gen`

## Requirements
- R1: A census signature has 24 bits. Window pixel (r,c) sits at `win[(r*5+c)*8 +: 8]`, and index 12 is the centre, which is excluded. Neighbour index i maps to signature bit i when i<12 and to bit i-1 when i>12. A bit is 1 when that neighbour is strictly less than the centre.
- R2: For a disparity inside the image, the cost is the Hamming distance between the current and reference signatures. It is zero-extended to a 6-bit entry, so its range is 0 to 24.
- R3: The g-th accepted beat of a pixel (g counts from 0) evaluates disparity d = g*LANES + k on lane k. Lane k takes its reference window from `ref_win_i[k*200 +: 200]`. The result lands in `cost_vec_o[d*6 +: 6]`. `cur_win_i` and `col_i` are sampled on every beat.
- R4: A disparity d greater than `col_i`, whose reference column x−d is negative, gets cost 63.
- R5: A pixel completes after 64/LANES accepted beats. `cost_vld_o` is high for exactly one cycle: the cycle after the clock edge that accepts the final beat. It is low at all other times.
- R6: Cycles with `beat_vld_i` low are ignored. They neither advance the beat count nor produce output.
- R7: While `rst_ni` is low, `cost_vld_o` is low and `cost_vec_o` reads zero. After reset the beat count starts again at zero, and any partially received pixel is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| beat_vld_i | input | 1 | Beat accepted on this edge |
| col_i | input | COL_W (11) | Column of the current pixel in the image |
| cur_win_i | input | 25*PIX_W (200) | 5×5 current-image window |
| ref_win_i | input | LANES*25*PIX_W (1600) | One reference window per lane |
| cost_vld_o | output | 1 | Cost vector complete, one-cycle strobe |
| cost_vec_o | output | NDISP*COST_W (384) | Cost per disparity, entry d at bits d*6 |

## Verification
The costs for each beat are written into the result register on the edge that accepts that beat. The completion strobe is set on that same edge after the final beat, so the whole vector is due one cycle after the last beat is taken. The bench drives beats on falling edges and reads the strobe and vector at the next falling edge after the final beat. At the falling edges between earlier beats, and inside inserted idle cycles, it confirms the strobe is still low. Expected costs come from a census and popcount model written in the bench from the stated bit mapping.

// File: rtl/census_cost_pkg.sv
package census_cost_pkg;
  localparam int unsigned CC_PIX_W  = 8;
  localparam int unsigned CC_WIN    = 5;
  localparam int unsigned CC_NDISP  = 64;
  localparam int unsigned CC_LANES  = 8;
  localparam int unsigned CC_COST_W = 6;
  localparam int unsigned CC_COL_W  = 11;

  // number of census bits for a square window of side w
  function automatic int unsigned census_bits(int unsigned w);
    return w * w - 1;
  endfunction
endpackage

// File: rtl/census_unit.sv
module census_unit #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned WIN   = 5
) (
  input  logic [WIN*WIN*PIX_W-1:0] win_i,
  output logic [WIN*WIN-2:0]       census_o
);
  localparam int unsigned NPIX = WIN * WIN;
  localparam int unsigned CTR  = NPIX / 2;

  logic [PIX_W-1:0] ctr_pix;
  assign ctr_pix = win_i[CTR*PIX_W +: PIX_W];

  for (genvar i = 0; i < NPIX; i++) begin : g_nb
    if (i < CTR) begin : g_lo
      assign census_o[i] = win_i[i*PIX_W +: PIX_W] < ctr_pix;
    end else if (i > CTR) begin : g_hi
      assign census_o[i-1] = win_i[i*PIX_W +: PIX_W] < ctr_pix;
    end
  end
endmodule

// File: rtl/cost_lane.sv
module cost_lane #(
  parameter int unsigned CBITS  = 24,
  parameter int unsigned COST_W = 6,
  parameter int unsigned DISP_W = 6,
  parameter int unsigned COL_W  = 11
) (
  input  logic [CBITS-1:0]  cur_cen_i,
  input  logic [CBITS-1:0]  ref_cen_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [COST_W-1:0] cost_o
);
  localparam int unsigned HW = $clog2(CBITS + 1);

  logic [CBITS-1:0] diff;
  logic [HW-1:0]    cnt;
  logic             oob;

  assign diff = cur_cen_i ^ ref_cen_i;
  assign oob  = 32'(disp_i) > 32'(col_i);

  always_comb begin
    cnt = '0;
    for (int b = 0; b < CBITS; b++) cnt = cnt + HW'(diff[b]);
  end

  assign cost_o = oob ? '1 : COST_W'(cnt);
endmodule

// File: rtl/census_cost_gen.sv
module census_cost_gen
  import census_cost_pkg::*;
#(
  parameter int unsigned PIX_W  = CC_PIX_W,
  parameter int unsigned WIN    = CC_WIN,
  parameter int unsigned NDISP  = CC_NDISP,
  parameter int unsigned LANES  = CC_LANES,
  parameter int unsigned COST_W = CC_COST_W,
  parameter int unsigned COL_W  = CC_COL_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           beat_vld_i,
  input  logic [COL_W-1:0]               col_i,
  input  logic [WIN*WIN*PIX_W-1:0]       cur_win_i,
  input  logic [LANES*WIN*WIN*PIX_W-1:0] ref_win_i,
  output logic                           cost_vld_o,
  output logic [NDISP*COST_W-1:0]        cost_vec_o
);
  localparam int unsigned WBITS  = WIN * WIN * PIX_W;
  localparam int unsigned CBITS  = census_bits(WIN);
  localparam int unsigned GROUPS = NDISP / LANES;
  localparam int unsigned GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int unsigned DISP_W = (NDISP > 1) ? $clog2(NDISP) : 1;

  logic [GRP_W-1:0]       grp_q;
  logic                   last_beat;
  logic                   vld_q;
  logic [NDISP*COST_W-1:0] acc_q;
  logic [CBITS-1:0]       cur_cen;
  logic [COST_W-1:0]      lane_cost [LANES];
  logic [DISP_W-1:0]      lane_disp [LANES];

  assign last_beat = (grp_q == GRP_W'(GROUPS - 1));

  census_unit #(.PIX_W(PIX_W), .WIN(WIN)) u_cur_cen (
    .win_i    (cur_win_i),
    .census_o (cur_cen)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CBITS-1:0] ref_cen;

    assign lane_disp[k] = DISP_W'(int'(grp_q) * LANES + k);

    census_unit #(.PIX_W(PIX_W), .WIN(WIN)) u_ref_cen (
      .win_i    (ref_win_i[k*WBITS +: WBITS]),
      .census_o (ref_cen)
    );

    cost_lane #(
      .CBITS (CBITS), .COST_W(COST_W), .DISP_W(DISP_W), .COL_W(COL_W)
    ) u_lane (
      .cur_cen_i (cur_cen),
      .ref_cen_i (ref_cen),
      .disp_i    (lane_disp[k]),
      .col_i     (col_i),
      .cost_o    (lane_cost[k])
    );

    p_cost_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (beat_vld_i && (32'(lane_disp[k]) <= 32'(col_i))) |-> (32'(lane_cost[k]) <= CBITS));
  end

  // beat counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= beat_vld_i && last_beat;
      if (beat_vld_i) grp_q <= last_beat ? '0 : grp_q + 1'b1;
    end
  end

  // cost collection, slot chosen by beat index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (beat_vld_i) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (grp_q == GRP_W'(g)) begin
          for (int k = 0; k < LANES; k++)
            acc_q[(g*LANES+k)*COST_W +: COST_W] <= lane_cost[k];
        end
      end
    end
  end

  assign cost_vld_o = vld_q;
  assign cost_vec_o = acc_q;

  p_vld_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cost_vld_o |-> $past(beat_vld_i));

  p_vld_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cost_vld_o |-> (grp_q == '0));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_vld_i |=> $stable(grp_q));

  if (GROUPS > 1) begin : g_pulse_chk
    p_vld_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cost_vld_o |=> !cost_vld_o);
  end
endmodule

// File: tb/sim_census_cost_gen.sv
`timescale 1ns/1ps
module sim_census_cost_gen;
  localparam int LANES  = 8;
  localparam int NDISP  = 64;
  localparam int GROUPS = NDISP / LANES;
  localparam int WB     = 200;

  // {col, seed, mode, gap}; mode 0 random, 1 ref==cur, 2 max-distance, 3 flat current
  localparam int TBL [8][4] = '{
    '{70, 1, 0, 0}, '{0, 2, 0, 0}, '{31, 3, 0, 1}, '{63, 4, 1, 0},
    '{10, 5, 2, 0}, '{64, 6, 3, 1}, '{5, 7, 0, 1}, '{100, 8, 0, 0}
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  beat_vld = 1'b0;
  logic [10:0]           col = '0;
  logic [WB-1:0]         cur_win = '0;
  logic [LANES*WB-1:0]   ref_win = '0;
  logic                  cost_vld;
  logic [NDISP*6-1:0]    cost_vec;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  census_cost_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .beat_vld_i(beat_vld), .col_i(col),
    .cur_win_i(cur_win), .ref_win_i(ref_win),
    .cost_vld_o(cost_vld), .cost_vec_o(cost_vec)
  );

  function automatic logic [7:0] hsh(int seed, int d, int idx);
    int unsigned v;
    v = unsigned'(seed) * 32'd73 + unsigned'(d + 2) * 32'd151 + unsigned'(idx) * 32'd29;
    v = v * 32'd2654435761;
    return v[20:13];
  endfunction

  function automatic logic [7:0] px(int mode, int seed, int d, int idx);
    case (mode)
      0: return hsh(seed, d, idx);
      1: return hsh(seed, -1, idx);
      2: if (d < 0) return (idx == 12) ? 8'd255 : 8'd0;
         else       return (idx == 12) ? 8'd0 : 8'd255;
      3: return (d < 0) ? 8'd100 : hsh(seed, d, idx);
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [WB-1:0] mkwin(int mode, int seed, int d);
    logic [WB-1:0] w;
    for (int i = 0; i < 25; i++) w[i*8 +: 8] = px(mode, seed, d, i);
    return w;
  endfunction

  // R1 signature model
  function automatic logic [23:0] cen(logic [WB-1:0] w);
    logic [23:0] c;
    int j;
    j = 0;
    for (int i = 0; i < 25; i++) begin
      if (i != 12) begin
        c[j] = w[i*8 +: 8] < w[96 +: 8];
        j++;
      end
    end
    return c;
  endfunction

  function automatic int pc(logic [23:0] x);
    int n;
    n = 0;
    for (int b = 0; b < 24; b++) n += int'(x[b]);
    return n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drives one pixel; vector due at the falling edge after the final beat
  task automatic send_pixel(int c, int seed, int mode, int gap);
    bit early;
    early = 1'b0;
    cur_win = mkwin(mode, seed, -1);
    for (int g = 0; g < GROUPS; g++) begin
      @(negedge clk);
      if (g > 0 && cost_vld) early = 1'b1;
      beat_vld = 1'b1;
      col = 11'(c);
      for (int k = 0; k < LANES; k++) ref_win[k*WB +: WB] = mkwin(mode, seed, g*LANES + k);
      if (gap != 0 && g < GROUPS - 1) begin
        @(negedge clk);
        if (cost_vld) early = 1'b1;
        beat_vld = 1'b0;  // idle cycle, R6
      end
    end
    @(negedge clk);
    beat_vld = 1'b0;
    chk(!early, "R5 R6 strobe low before final beat", int'(early), 0);
    chk(cost_vld == 1'b1, "R5 strobe after final beat", int'(cost_vld), 1);
    begin
      int bad_in, bad_out, a_in, e_in, a_out, e_out;
      bad_in = 0; bad_out = 0; a_in = 0; e_in = 0; a_out = 0; e_out = 0;
      for (int d = 0; d < NDISP; d++) begin
        int exp, act;
        act = int'(cost_vec[d*6 +: 6]);
        if (d > c) exp = 63;
        else exp = pc(cen(cur_win) ^ cen(mkwin(mode, seed, d)));
        if (act != exp) begin
          if (d > c) begin
            if (bad_out == 0) begin a_out = act; e_out = exp; end
            bad_out++;
          end else begin
            if (bad_in == 0) begin a_in = act; e_in = exp; end
            bad_in++;
          end
        end
      end
      // in-image entries cover R1 R2 R3; out-of-image entries R4
      chk(bad_in == 0, "R1 R2 R3 in-image cost", a_in, e_in);
      chk(bad_out == 0, "R4 out-of-image cost", a_out, e_out);
    end
  endtask

  initial begin
    bit seen;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cost_vld == 1'b0, "R7 reset strobe", int'(cost_vld), 0);
    chk(cost_vec == '0, "R7 reset vector", int'(cost_vec[5:0]), 0);
    rst_n = 1'b1;

    // idle cycles produce nothing (R6)
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (cost_vld) seen = 1'b1;
    end
    chk(!seen, "R6 idle no strobe", int'(seen), 0);

    for (int t = 0; t < 8; t++)
      send_pixel(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3]);

    // R7: partial pixel then reset, next pixel must align to beat 0
    for (int g = 0; g < 3; g++) begin
      @(negedge clk);
      beat_vld = 1'b1;
      col = 11'd40;
      for (int k = 0; k < LANES; k++) ref_win[k*WB +: WB] = mkwin(0, 9, 50 + k);
    end
    @(negedge clk);
    beat_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cost_vld == 1'b0, "R7 strobe low in reset", int'(cost_vld), 0);
    chk(cost_vec == '0, "R7 vector cleared", int'(cost_vec[5:0]), 0);
    rst_n = 1'b1;
    send_pixel(45, 11, 0, 0);

    repeat (2) @(negedge clk);
    chk(cost_vld == 1'b0, "R5 strobe one cycle only", int'(cost_vld), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule